// File: doc/BRIEF.md
# Data Valid Window Scanner

This block measures the read-capture timing margin of each byte group in a memory read path. A start pulse launches a sweep over the byte groups in turn. For each group the block moves an external fine phase-delay line one tap at a time in the increment direction. It waits a programmable settle time after every tap and then samples a compare-error flag from an external data checker. When the flag rises, or when a per-side tap limit is reached, it moves the line back by the same number of taps. It then pulses an error-clear strobe and sweeps the decrement side the same way. It also moves back from that side and clears the error once more.

The two tap counts are added and the sum is converted to picoseconds. One tap is one 128th of the clock period, so the result is the floor of taps × period / 128. The total, the time value and a timeout flag are written to a small result array indexed by byte group. A select input reads any entry back with one cycle of latency. While a sweep runs, the calibrated-tap-valid output is low, because the delay line is then away from its centred setting.

The controller is one state machine. IDLE goes to STEP_A on start. STEP_A (one increment pulse) goes to WAIT_A. WAIT_A returns to STEP_A until the settle time ends and either the error is seen or the limit is hit, and then goes to BACK_A. BACK_A issues decrement pulses and goes to CLEAR_A after the last one. CLEAR_A goes to STEP_B. STEP_B, WAIT_B, BACK_B and CLEAR_B mirror the first side with the directions swapped. CLEAR_B goes to STORE. STORE returns to STEP_A for the next group, or goes to FINISH after the last group. FINISH goes to IDLE.

Top module: `eye_margin_scanner`

## Requirements
- R1: After reset, busy_o, done_o, tap_inc_o, tap_dec_o and err_clr_o are 0, cal_tap_valid_o is 1, and every stored entry reads back as zero.
- R2: The first side of each group issues single-cycle tap_inc_o pulses and counts them until cmp_err_i is seen high. The side count equals the number of pulses issued when the error was sampled. tap_inc_o and tap_dec_o are never high together.
- R3: After the first side ends, exactly as many tap_dec_o pulses are issued on consecutive cycles, so the delay line returns to its starting tap before the clear pulse.
- R4: After each return, err_clr_o is high for exactly one cycle with no tap pulse in that cycle. The second side starts only after this pulse.
- R5: The second side uses tap_dec_o pulses in the same way, and is then undone by the same number of tap_inc_o pulses followed by another clear pulse.
- R6: The stored total is the sum of both side counts. The stored time is floor(total × CLK_PERIOD_PS / 128) picoseconds.
- R7: A side that reaches MAX_TAPS pulses without an error stops with a count of MAX_TAPS and sets the entry's timeout flag. An error sampled on the MAX_TAPS-th tap is an ordinary edge, and the flag stays clear.
- R8: settle_i is captured at start. After every scan pulse the block waits settle_i+1 cycles before it samples cmp_err_i, so one group takes (settle+3)×(countA+countB)+3 cycles. busy_o is high for the sum over all groups plus one.
- R9: rd_sel_i selects an entry, and rd_taps_o, rd_ps_o and rd_timeout_o show it one clock later.
- R10: busy_o is high from the cycle after start until done_o. done_o pulses once, in the final busy cycle. cal_tap_valid_o is low exactly while busy_o is high.
- R11: Groups are swept in ascending order, scan_grp_o names the group being scanned, and each result goes to that group's entry.
- R12: A start pulse while busy_o is high is ignored: the timing, the results and the single done pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a sweep of all groups when idle |
| settle_i | input | SETTLE_W | Settle cycles after each scan pulse, captured at start |
| cmp_err_i | input | 1 | Compare-error flag from the external data checker |
| tap_inc_o | output | 1 | One-cycle increment pulse to the delay line |
| tap_dec_o | output | 1 | One-cycle decrement pulse to the delay line |
| err_clr_o | output | 1 | One-cycle clear pulse to the data checker |
| scan_grp_o | output | GRP_W | Byte group being scanned |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Pulses in the final cycle of a sweep |
| cal_tap_valid_o | output | 1 | Low while the tap setting is off-centre |
| rd_sel_i | input | GRP_W | Result entry to read |
| rd_taps_o | output | TAP_W+1 | Stored total taps |
| rd_ps_o | output | PS_W | Stored window width in ps |
| rd_timeout_o | output | 1 | Stored timeout flag |

## Verification
The hardest conditions to reach from the ports are the saturation boundaries and a stale error during a return. The bench runs a delay-line model per group with its own window edges. An edge placed at exactly MAX_TAPS gives an ordinary edge, and one placed at MAX_TAPS+1 or beyond gives a timeout. The model latches its error until err_clr_o, so every return sweep runs with the error still high, and the model's tap position is checked to be zero at each clear pulse. A second start pulse in the middle of a sweep, and two settle settings, check the cycle-count formula.

// File: rtl/ems_pkg.sv
package ems_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STEP_A,
        S_WAIT_A,
        S_BACK_A,
        S_CLEAR_A,
        S_STEP_B,
        S_WAIT_B,
        S_BACK_B,
        S_CLEAR_B,
        S_STORE,
        S_FINISH
    } scan_state_e;

endpackage

// File: rtl/ems_settle_timer.sv
module ems_settle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ems_tap_to_ps.sv
module ems_tap_to_ps #(
    parameter int TOT_W     = 7,
    parameter int PERIOD_PS = 2500,
    parameter int PS_W      = 12
) (
    input  logic [TOT_W-1:0] taps_i,
    output logic [PS_W-1:0]  ps_o
);

    localparam int PROD_W = PS_W + 7;

    logic [PROD_W-1:0] prod;

    // one tap is a 128th of the clock period: multiply, then drop 7 bits
    assign prod = PROD_W'(taps_i) * PROD_W'(PERIOD_PS);
    assign ps_o = prod[PROD_W-1:7];

endmodule

// File: rtl/ems_result_ram.sv
module ems_result_ram #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we_i && (int'(waddr_i) < DEPTH)) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (int'(raddr_i) < DEPTH) begin
            rdata_o <= mem_q[raddr_i];
        end else begin
            rdata_o <= '0;
        end
    end

endmodule

// File: rtl/eye_margin_scanner.sv
module eye_margin_scanner
    import ems_pkg::*;
#(
    parameter int NUM_GROUPS    = 4,
    parameter int MAX_TAPS      = 63,
    parameter int CLK_PERIOD_PS = 2500,
    parameter int SETTLE_W      = 4,
    localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int TAP_W  = $clog2(MAX_TAPS + 1),
    localparam int TOT_W  = TAP_W + 1,
    localparam int PER_W  = $clog2(CLK_PERIOD_PS + 1),
    localparam int PS_W   = TOT_W + PER_W - 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                cmp_err_i,
    output logic                tap_inc_o,
    output logic                tap_dec_o,
    output logic                err_clr_o,
    output logic [GRP_W-1:0]    scan_grp_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                cal_tap_valid_o,
    input  logic [GRP_W-1:0]    rd_sel_i,
    output logic [TOT_W-1:0]    rd_taps_o,
    output logic [PS_W-1:0]     rd_ps_o,
    output logic                rd_timeout_o
);

    localparam int ENTRY_W = 1 + TOT_W + PS_W;
    localparam logic [TAP_W-1:0] TAP_LIMIT = TAP_W'(MAX_TAPS);
    localparam logic [GRP_W-1:0] LAST_GRP  = GRP_W'(NUM_GROUPS - 1);

    scan_state_e state_q, state_d;

    logic [TAP_W-1:0]    cnt_a_q, cnt_b_q, ret_q;
    logic                to_a_q, to_b_q;
    logic [GRP_W-1:0]    grp_q;
    logic [SETTLE_W-1:0] settle_q;
    logic                settle_load, settle_done;
    logic [TOT_W-1:0]    total;
    logic [PS_W-1:0]     total_ps;
    logic                store_we;
    logic [ENTRY_W-1:0]  wr_entry, rd_entry;

    ems_settle_timer #(
        .W (SETTLE_W)
    ) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (settle_load),
        .value_i   (settle_q),
        .expired_o (settle_done)
    );

    ems_tap_to_ps #(
        .TOT_W     (TOT_W),
        .PERIOD_PS (CLK_PERIOD_PS),
        .PS_W      (PS_W)
    ) u_conv (
        .taps_i (total),
        .ps_o   (total_ps)
    );

    ems_result_ram #(
        .DEPTH  (NUM_GROUPS),
        .ADDR_W (GRP_W),
        .DATA_W (ENTRY_W)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (store_we),
        .waddr_i (grp_q),
        .wdata_i (wr_entry),
        .raddr_i (rd_sel_i),
        .rdata_o (rd_entry)
    );

    assign total    = TOT_W'(cnt_a_q) + TOT_W'(cnt_b_q);
    assign wr_entry = {to_a_q | to_b_q, total, total_ps};
    assign {rd_timeout_o, rd_taps_o, rd_ps_o} = rd_entry;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = S_STEP_A;
            S_STEP_A:  state_d = S_WAIT_A;
            S_WAIT_A: begin
                if (settle_done) begin
                    if (cmp_err_i || (cnt_a_q == TAP_LIMIT)) state_d = S_BACK_A;
                    else                                     state_d = S_STEP_A;
                end
            end
            S_BACK_A:  if (ret_q == TAP_W'(1)) state_d = S_CLEAR_A;
            S_CLEAR_A: state_d = S_STEP_B;
            S_STEP_B:  state_d = S_WAIT_B;
            S_WAIT_B: begin
                if (settle_done) begin
                    if (cmp_err_i || (cnt_b_q == TAP_LIMIT)) state_d = S_BACK_B;
                    else                                     state_d = S_STEP_B;
                end
            end
            S_BACK_B:  if (ret_q == TAP_W'(1)) state_d = S_CLEAR_B;
            S_CLEAR_B: state_d = S_STORE;
            S_STORE:   state_d = (grp_q == LAST_GRP) ? S_FINISH : S_STEP_A;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // counters, flags and group index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_a_q  <= '0;
            cnt_b_q  <= '0;
            ret_q    <= '0;
            to_a_q   <= 1'b0;
            to_b_q   <= 1'b0;
            grp_q    <= '0;
            settle_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        cnt_a_q  <= '0;
                        cnt_b_q  <= '0;
                        to_a_q   <= 1'b0;
                        to_b_q   <= 1'b0;
                        grp_q    <= '0;
                        settle_q <= settle_i;
                    end
                end
                S_STEP_A: cnt_a_q <= cnt_a_q + 1'b1;
                S_WAIT_A: begin
                    if (settle_done && (cmp_err_i || (cnt_a_q == TAP_LIMIT))) begin
                        ret_q  <= cnt_a_q;
                        to_a_q <= !cmp_err_i;
                    end
                end
                S_BACK_A: ret_q <= ret_q - 1'b1;
                S_STEP_B: cnt_b_q <= cnt_b_q + 1'b1;
                S_WAIT_B: begin
                    if (settle_done && (cmp_err_i || (cnt_b_q == TAP_LIMIT))) begin
                        ret_q  <= cnt_b_q;
                        to_b_q <= !cmp_err_i;
                    end
                end
                S_BACK_B: ret_q <= ret_q - 1'b1;
                S_STORE: begin
                    cnt_a_q <= '0;
                    cnt_b_q <= '0;
                    to_a_q  <= 1'b0;
                    to_b_q  <= 1'b0;
                    if (grp_q != LAST_GRP) grp_q <= grp_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        tap_inc_o       = 1'b0;
        tap_dec_o       = 1'b0;
        err_clr_o       = 1'b0;
        settle_load     = 1'b0;
        store_we        = 1'b0;
        done_o          = 1'b0;
        busy_o          = 1'b1;
        unique case (state_q)
            S_IDLE:    busy_o = 1'b0;
            S_STEP_A: begin
                tap_inc_o   = 1'b1;
                settle_load = 1'b1;
            end
            S_BACK_A:  tap_dec_o = 1'b1;
            S_CLEAR_A: err_clr_o = 1'b1;
            S_STEP_B: begin
                tap_dec_o   = 1'b1;
                settle_load = 1'b1;
            end
            S_BACK_B:  tap_inc_o = 1'b1;
            S_CLEAR_B: err_clr_o = 1'b1;
            S_STORE:   store_we  = 1'b1;
            S_FINISH:  done_o    = 1'b1;
            default: ;
        endcase
        cal_tap_valid_o = !busy_o;
    end

    assign scan_grp_o = grp_q;

endmodule

// File: rtl/eye_margin_scanner_chk.sv
module eye_margin_scanner_chk #(
    parameter int NUM_GROUPS = 4,
    parameter int MAX_TAPS   = 63,
    parameter int GRP_W      = 2,
    parameter int TOT_W      = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tap_inc_o,
    input logic             tap_dec_o,
    input logic             err_clr_o,
    input logic [GRP_W-1:0] scan_grp_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             cal_tap_valid_o,
    input logic [TOT_W-1:0] rd_taps_o
);

    a_r2_no_dual_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(tap_inc_o && tap_dec_o));

    a_r2_first_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> tap_inc_o);

    a_r4_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_o |=> !err_clr_o);

    a_r4_clear_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_o |-> !tap_inc_o && !tap_dec_o);

    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    a_r10_done_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o && !cal_tap_valid_o);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !tap_inc_o && !tap_dec_o && !err_clr_o);

    a_r11_grp_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(scan_grp_o) < NUM_GROUPS);

    a_r7_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_taps_o) <= 2 * MAX_TAPS);

endmodule

bind eye_margin_scanner eye_margin_scanner_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .MAX_TAPS   (MAX_TAPS),
    .GRP_W      (GRP_W),
    .TOT_W      (TOT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tap_inc_o       (tap_inc_o),
    .tap_dec_o       (tap_dec_o),
    .err_clr_o       (err_clr_o),
    .scan_grp_o      (scan_grp_o),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .cal_tap_valid_o (cal_tap_valid_o),
    .rd_taps_o       (rd_taps_o)
);

// File: tb/tb_eye_margin_scanner.sv
module tb_eye_margin_scanner;

    localparam int NG   = 4;
    localparam int MAXT = 63;
    localparam int PER  = 2500;
    localparam int SW   = 4;

    typedef struct {
        int grp;
        int taps;
        int ps;
        int to;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [SW-1:0] settle_i = '0;
    logic          cmp_err_i;
    logic          tap_inc_o, tap_dec_o, err_clr_o;
    logic [1:0]    scan_grp_o;
    logic          busy_o, done_o, cal_tap_valid_o;
    logic [1:0]    rd_sel_i = '0;
    logic [6:0]    rd_taps_o;
    logic [11:0]   rd_ps_o;
    logic          rd_timeout_o;

    int   vec = 0;
    int   fails = 0;
    exp_t sb_q[$];
    int   right_edge [NG];
    int   left_edge  [NG];
    int   pos        [NG];
    logic err_q = 1'b0;
    int   busy_cnt = 0, done_cnt = 0, rb_count = 0, valid_bad = 0;
    bit   mon_on = 1'b0;

    always #10 clk = ~clk;

    eye_margin_scanner #(
        .NUM_GROUPS    (NG),
        .MAX_TAPS      (MAXT),
        .CLK_PERIOD_PS (PER),
        .SETTLE_W      (SW)
    ) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .settle_i        (settle_i),
        .cmp_err_i       (cmp_err_i),
        .tap_inc_o       (tap_inc_o),
        .tap_dec_o       (tap_dec_o),
        .err_clr_o       (err_clr_o),
        .scan_grp_o      (scan_grp_o),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .cal_tap_valid_o (cal_tap_valid_o),
        .rd_sel_i        (rd_sel_i),
        .rd_taps_o       (rd_taps_o),
        .rd_ps_o         (rd_ps_o),
        .rd_timeout_o    (rd_timeout_o)
    );

    assign cmp_err_i = err_q;

    // delay-line and checker model: latched error, cleared by err_clr_o
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NG; i++) pos[i] <= 0;
            err_q <= 1'b0;
        end else begin
            int g, np;
            g  = int'(scan_grp_o);
            np = pos[g] + (tap_inc_o ? 1 : 0) - (tap_dec_o ? 1 : 0);
            pos[g] <= np;
            err_q  <= (err_q && !err_clr_o) || (np >= right_edge[g]) || (np <= -left_edge[g]);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: activity counts, position at clear, scoreboard readback at done
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (busy_o) busy_cnt++;
                if (cal_tap_valid_o == busy_o) valid_bad++;
                if (err_clr_o) begin
                    // R3 R5: delay line back at its starting tap at every clear
                    chk(pos[scan_grp_o] == 0, "R3/R5 tap position at clear",
                        pos[scan_grp_o], 0);
                end
                if (done_o) begin
                    done_cnt++;
                    @(negedge clk);
                    if (busy_o) valid_bad++;
                    while (sb_q.size() > 0) begin
                        exp_t e;
                        e = sb_q.pop_front();
                        rd_sel_i = 2'(e.grp);
                        @(negedge clk);
                        chk(int'(rd_taps_o) == e.taps, "R6 R11 total taps", int'(rd_taps_o), e.taps);
                        chk(int'(rd_ps_o) == e.ps, "R6 R9 window ps", int'(rd_ps_o), e.ps);
                        chk(int'(rd_timeout_o) == e.to, "R7 timeout flag", int'(rd_timeout_o), e.to);
                    end
                    rb_count++;
                end
            end
        end
    end

    // driver: sets windows, pushes expectations, starts the sweep
    task automatic run_sweep(input int settle, input int rr[NG], input int ll[NG], input bit restart);
        int exp_busy, prev;
        exp_busy = 1;
        for (int g = 0; g < NG; g++) begin
            exp_t e;
            int ca, cb, ta, tb;
            right_edge[g] = rr[g];
            left_edge[g]  = ll[g];
            ca = (rr[g] > MAXT) ? MAXT : rr[g];
            ta = (rr[g] > MAXT) ? 1 : 0;
            cb = (ll[g] > MAXT) ? MAXT : ll[g];
            tb = (ll[g] > MAXT) ? 1 : 0;
            e.grp  = g;
            e.taps = ca + cb;
            e.ps   = ((ca + cb) * PER) / 128;
            e.to   = ta | tb;
            sb_q.push_back(e);
            exp_busy += (settle + 3) * (ca + cb) + 3;
        end
        busy_cnt  = 0;
        done_cnt  = 0;
        valid_bad = 0;
        prev      = rb_count;
        @(negedge clk);
        settle_i = SW'(settle);
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        settle_i = '0;
        if (restart) begin
            repeat (25) @(negedge clk);
            start_i = 1'b1;   // R12: must be ignored
            @(negedge clk);
            start_i = 1'b0;
        end
        while (rb_count == prev) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy_cnt == exp_busy, "R8 R12 busy cycles", busy_cnt, exp_busy);
        chk(done_cnt == 1, "R10 R12 done pulses", done_cnt, 1);
        chk(valid_bad == 0, "R10 cal_tap_valid vs busy", valid_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end

    initial begin
        for (int g = 0; g < NG; g++) begin
            right_edge[g] = 1000;
            left_edge[g]  = 1000;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rd_sel_i = 2'd2;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!busy_o && !done_o, "R1 busy/done low", int'(busy_o), 0);
        chk(!tap_inc_o && !tap_dec_o && !err_clr_o, "R1 pulses low",
            int'({tap_inc_o, tap_dec_o, err_clr_o}), 0);
        chk(cal_tap_valid_o, "R1 cal valid", int'(cal_tap_valid_o), 1);
        chk(rd_taps_o == '0 && rd_ps_o == '0 && !rd_timeout_o, "R1 entry cleared",
            int'(rd_taps_o), 0);
        mon_on = 1'b1;

        // R2 R3 R5 R7: edge at MAX_TAPS is an edge, beyond it a timeout
        run_sweep(0, '{5, 1, 63, 64}, '{7, 1, 2, 10}, 1'b0);
        // R8 R12: longer settle, second start while busy, left-side timeout
        run_sweep(3, '{3, 12, 2, 40}, '{100, 4, 9, 1}, 1'b1);
        // R9: reread one entry with a changed select
        rd_sel_i = 2'd1;
        @(negedge clk);
        chk(int'(rd_taps_o) == 16, "R9 reread group 1", int'(rd_taps_o), 16);

        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end

endmodule